// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how each of the five pipeline registers of an in-order processor (fetch, decode, execute, memory, write-back) advances. From the instruction codes held in decode, execute and memory, the execute-stage load destination, the decode source register IDs, the execute branch outcome and the status codes of the memory and write-back stages, it derives stall and bubble controls and the enable for condition-code updates. The conditions it recognises are load/use hazards, returns in flight, not-taken conditional jumps that were predicted taken, and faulting instructions near retirement.

Conflicting conditions in one cycle are resolved by fixed priority so that no register is ever told to stall and bubble at once. The unit also contains five copies of a generic pipeline register, each carrying an opaque payload and driven by the computed controls. The register holds on stall, loads a no-operation pattern on bubble and otherwise captures its input. A standalone copy flags a simultaneous stall and bubble as an error and lets stall win.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the execute opcode is a load (0x5) or pop (0xB) and its memory destination ID equals either decode source ID, f_stall, d_stall and e_bubble are high and d_bubble is low.
- R2: Register ID 0xF means "no register" and never produces a load/use hazard, even when a source ID is also 0xF.
- R3: A return (opcode 0x9) in decode, execute or memory raises f_stall and d_bubble, unless R1 applies.
- R4: A conditional jump (opcode 0x7) in execute with e_cond low raises d_bubble and e_bubble; with e_cond high it causes no bubble.
- R5: Status is 2 bits (OK=0, HLT=1, ADR=2, INS=3); any non-zero m_stat or w_stat raises m_bubble and w_stall in the same cycle.
- R6: set_cc is high only when the execute opcode is an ALU operation (0x6) and both m_stat and w_stat are OK.
- R7: When a load/use hazard and a return coincide, decode is stalled and not bubbled, so the return stays in decode one more cycle.
- R8: When a mispredicted jump and a return coincide, f_stall, d_bubble and e_bubble are all high.
- R9: Stage registers are indexed F=0, D=1, E=2, M=3, W=4 in stg_d/stg_q; on a rising edge a stalled register keeps its value, a bubbled one loads NOP_PAY (default 0x10), and any other loads its input.
- R10: A pipeline register receiving stall and bubble together raises its conflict flag and keeps its value; ctl_err is the OR of the five flags and stays low.
- R11: During and after reset all stage registers hold NOP_PAY, and with idle inputs every control output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_op | input | 4 | Opcode in decode |
| e_op | input | 4 | Opcode in execute |
| m_op | input | 4 | Opcode in memory |
| e_dst_mem | input | 4 | Execute-stage memory-load destination ID |
| dec_src_a | input | 4 | Decode source ID A |
| dec_src_b | input | 4 | Decode source ID B |
| e_cond | input | 1 | Branch condition computed in execute |
| m_stat | input | 2 | Memory-stage status |
| w_stat | input | 2 | Write-back-stage status |
| stg_d | input | 5x8 | Next payload for each stage register |
| f_stall | output | 1 | Hold fetch register |
| d_stall | output | 1 | Hold decode register |
| d_bubble | output | 1 | Load no-op into decode register |
| e_bubble | output | 1 | Load no-op into execute register |
| m_bubble | output | 1 | Load no-op into memory register |
| w_stall | output | 1 | Hold write-back register |
| set_cc | output | 1 | Condition-code write enable |
| stg_q | output | 5x8 | Current payload of each stage register |
| ctl_err | output | 1 | Stall and bubble seen together on a register |

## Verification
The pairing that matters most is a load/use hazard against a return in flight: both want to act on the decode register, one by holding it and one by bubbling it. The bench provokes it by sweeping every mix of opcodes in decode, execute and memory together with matching and non-matching register IDs, so a load in execute with a return in decode occurs alongside every status and branch outcome. It judges the result by requiring d_stall high and d_bubble low in exactly those cycles, and by observing on the next edge that the decode payload was held rather than replaced with the no-op pattern.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  localparam int OP_W  = 4;
  localparam int RID_W = 4;
  localparam int NSTG  = 5;

  localparam int STG_F = 0;
  localparam int STG_D = 1;
  localparam int STG_E = 2;
  localparam int STG_M = 3;
  localparam int STG_W = 4;

  localparam logic [OP_W-1:0] OP_NOP  = 4'h1;
  localparam logic [OP_W-1:0] OP_LOAD = 4'h5;
  localparam logic [OP_W-1:0] OP_ALU  = 4'h6;
  localparam logic [OP_W-1:0] OP_JMP  = 4'h7;
  localparam logic [OP_W-1:0] OP_RET  = 4'h9;
  localparam logic [OP_W-1:0] OP_POP  = 4'hB;

  localparam logic [RID_W-1:0] RID_NONE = '1;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_HLT = 2'd1,
    ST_ADR = 2'd2,
    ST_INS = 2'd3
  } stat_e;

  typedef struct packed {
    logic load_use;
    logic ret_busy;
    logic mispred;
    logic fault;
    logic alu_in_e;
  } hz_cond_t;
endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/hzd_detect.sv
`timescale 1ns/1ps
module hzd_detect
  import hzd_pkg::*;
(
  input  logic [OP_W-1:0]  d_op,
  input  logic [OP_W-1:0]  e_op,
  input  logic [OP_W-1:0]  m_op,
  input  logic [RID_W-1:0] e_dst_mem,
  input  logic [RID_W-1:0] src_a,
  input  logic [RID_W-1:0] src_b,
  input  logic             e_cond,
  input  logic [1:0]       m_stat,
  input  logic [1:0]       w_stat,
  output hz_cond_t         cond
);
  logic  e_is_ld;
  logic  dst_hit;
  stat_e ms, ws;

  always_comb begin
    ms      = stat_e'(m_stat);
    ws      = stat_e'(w_stat);
    e_is_ld = (e_op == OP_LOAD) || (e_op == OP_POP);
    dst_hit = (e_dst_mem != RID_NONE) &&
              ((e_dst_mem == src_a) || (e_dst_mem == src_b));

    cond.load_use = e_is_ld && dst_hit;
    cond.ret_busy = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
    cond.mispred  = (e_op == OP_JMP) && !e_cond;
    cond.fault    = (ms != ST_OK) || (ws != ST_OK);
    cond.alu_in_e = (e_op == OP_ALU);
  end
endmodule

// File: rtl/hzd_resolve.sv
`timescale 1ns/1ps
module hzd_resolve
  import hzd_pkg::*;
(
  input  hz_cond_t        cond,
  output logic [NSTG-1:0] stall,
  output logic [NSTG-1:0] bubble,
  output logic            set_cc
);
  always_comb begin
    stall  = '0;
    bubble = '0;

    // fetch holds for a load/use hazard or a return in flight
    stall[STG_F]  = cond.load_use || cond.ret_busy;
    // decode: load/use takes priority over the return bubble
    stall[STG_D]  = cond.load_use;
    bubble[STG_D] = cond.mispred || (cond.ret_busy && !cond.load_use);
    bubble[STG_E] = cond.mispred || cond.load_use;
    // faults near retirement freeze write-back and squash memory
    bubble[STG_M] = cond.fault;
    stall[STG_W]  = cond.fault;

    set_cc = cond.alu_in_e && !cond.fault;
  end
endmodule

// File: rtl/pipe_stage_reg.sv
`timescale 1ns/1ps
module pipe_stage_reg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] NOP_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         conflict
);
  logic         ld_en;
  logic [W-1:0] q_nxt;

  always_comb begin
    ld_en    = !stall;
    q_nxt    = bubble ? NOP_VAL : d;
    conflict = stall && bubble;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= NOP_VAL;
    else if (ld_en) q <= q_nxt;
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
`timescale 1ns/1ps
module pipe_hazard_ctl
  import hzd_pkg::*;
#(
  parameter int               PAY_W   = 8,
  parameter logic [PAY_W-1:0] NOP_PAY = 8'h10,
  parameter int               SYNC_N  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [3:0]                  d_op,
  input  logic [3:0]                  e_op,
  input  logic [3:0]                  m_op,
  input  logic [3:0]                  e_dst_mem,
  input  logic [3:0]                  dec_src_a,
  input  logic [3:0]                  dec_src_b,
  input  logic                        e_cond,
  input  logic [1:0]                  m_stat,
  input  logic [1:0]                  w_stat,
  input  logic [4:0][PAY_W-1:0]       stg_d,
  output logic                        f_stall,
  output logic                        d_stall,
  output logic                        d_bubble,
  output logic                        e_bubble,
  output logic                        m_bubble,
  output logic                        w_stall,
  output logic                        set_cc,
  output logic [4:0][PAY_W-1:0]       stg_q,
  output logic                        ctl_err
);
  hz_cond_t        cond;
  logic [NSTG-1:0] stall_v;
  logic [NSTG-1:0] bubble_v;
  logic [NSTG-1:0] conf_v;
  logic            srst_n;

  rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  hzd_detect u_det (
    .d_op      (d_op),
    .e_op      (e_op),
    .m_op      (m_op),
    .e_dst_mem (e_dst_mem),
    .src_a     (dec_src_a),
    .src_b     (dec_src_b),
    .e_cond    (e_cond),
    .m_stat    (m_stat),
    .w_stat    (w_stat),
    .cond      (cond)
  );

  hzd_resolve u_res (
    .cond   (cond),
    .stall  (stall_v),
    .bubble (bubble_v),
    .set_cc (set_cc)
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    pipe_stage_reg #(.W(PAY_W), .NOP_VAL(NOP_PAY)) u_reg (
      .clk      (clk),
      .rst_n    (srst_n),
      .stall    (stall_v[s]),
      .bubble   (bubble_v[s]),
      .d        (stg_d[s]),
      .q        (stg_q[s]),
      .conflict (conf_v[s])
    );
  end

  assign f_stall  = stall_v[STG_F];
  assign d_stall  = stall_v[STG_D];
  assign d_bubble = bubble_v[STG_D];
  assign e_bubble = bubble_v[STG_E];
  assign m_bubble = bubble_v[STG_M];
  assign w_stall  = stall_v[STG_W];
  assign ctl_err  = |conf_v;
endmodule

// File: rtl/hzd_ctl_chk.sv
`timescale 1ns/1ps
module hzd_ctl_chk
  import hzd_pkg::*;
#(
  parameter int               PAY_W   = 8,
  parameter logic [PAY_W-1:0] NOP_PAY = 8'h10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            d_op,
  input logic [3:0]            e_op,
  input logic [3:0]            m_op,
  input logic [3:0]            e_dst_mem,
  input logic [3:0]            dec_src_a,
  input logic [3:0]            dec_src_b,
  input logic                  e_cond,
  input logic [1:0]            m_stat,
  input logic [1:0]            w_stat,
  input logic                  f_stall,
  input logic                  d_stall,
  input logic                  d_bubble,
  input logic                  e_bubble,
  input logic                  m_bubble,
  input logic                  w_stall,
  input logic                  set_cc,
  input logic                  ctl_err,
  input logic [4:0][PAY_W-1:0] stg_q
);
  assert_lu_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (((e_op == OP_LOAD) || (e_op == OP_POP)) && (e_dst_mem != RID_NONE) &&
     ((e_dst_mem == dec_src_a) || (e_dst_mem == dec_src_b)))
    |-> (f_stall && d_stall && e_bubble && !d_bubble));

  assert_no_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (e_dst_mem == RID_NONE) |-> !d_stall);

  assert_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (((d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET)) && !d_stall)
    |-> (f_stall && d_bubble));

  assert_mispred_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((e_op == OP_JMP) && !e_cond) |-> (d_bubble && e_bubble));

  assert_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_stat != 2'd0) || (w_stat != 2'd0)) |-> (m_bubble && w_stall));

  assert_cc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_cc |-> ((m_stat == 2'd0) && (w_stat == 2'd0) && (e_op == OP_ALU)));

  assert_d_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_stall && d_bubble));

  assert_f_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    f_stall |=> (stg_q[0] == $past(stg_q[0])));

  assert_d_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    d_stall |=> (stg_q[1] == $past(stg_q[1])));

  assert_e_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    e_bubble |=> (stg_q[2] == NOP_PAY));

  assert_m_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_bubble |=> (stg_q[3] == NOP_PAY));

  assert_w_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    w_stall |=> (stg_q[4] == $past(stg_q[4])));

  assert_no_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_err);
endmodule

bind pipe_hazard_ctl hzd_ctl_chk #(.PAY_W(PAY_W), .NOP_PAY(NOP_PAY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .d_op      (d_op),
  .e_op      (e_op),
  .m_op      (m_op),
  .e_dst_mem (e_dst_mem),
  .dec_src_a (dec_src_a),
  .dec_src_b (dec_src_b),
  .e_cond    (e_cond),
  .m_stat    (m_stat),
  .w_stat    (w_stat),
  .f_stall   (f_stall),
  .d_stall   (d_stall),
  .d_bubble  (d_bubble),
  .e_bubble  (e_bubble),
  .m_bubble  (m_bubble),
  .w_stall   (w_stall),
  .set_cc    (set_cc),
  .ctl_err   (ctl_err),
  .stg_q     (stg_q)
);

// File: tb/tb_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module tb_pipe_hazard_ctl;
  localparam logic [7:0] NOPV = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] d_op, e_op, m_op, e_dst_mem, dec_src_a, dec_src_b;
  logic       e_cond;
  logic [1:0] m_stat, w_stat;
  logic [4:0][7:0] stg_d, stg_q;
  logic f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, set_cc, ctl_err;

  logic       sr_stall, sr_bubble, sr_conf;
  logic [7:0] sr_d, sr_q;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  pipe_hazard_ctl #(.PAY_W(8), .NOP_PAY(NOPV)) dut (
    .clk(clk), .rst_n(rst_n), .d_op(d_op), .e_op(e_op), .m_op(m_op),
    .e_dst_mem(e_dst_mem), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .e_cond(e_cond), .m_stat(m_stat), .w_stat(w_stat), .stg_d(stg_d),
    .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble),
    .e_bubble(e_bubble), .m_bubble(m_bubble), .w_stall(w_stall),
    .set_cc(set_cc), .stg_q(stg_q), .ctl_err(ctl_err)
  );

  pipe_stage_reg #(.W(8), .NOP_VAL(NOPV)) u_sr (
    .clk(clk), .rst_n(rst_n), .stall(sr_stall), .bubble(sr_bubble),
    .d(sr_d), .q(sr_q), .conflict(sr_conf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_stages(input string tag, input logic [4:0][7:0] exp);
    for (int s = 0; s < 5; s++) chk(tag, {24'd0, stg_q[s]}, {24'd0, exp[s]});
  endtask

  function automatic logic [6:0] model(input logic [3:0] dop, eop, mop, ed, sa, sb,
                                       input logic c, input logic [1:0] ms, ws);
    logic lu, rb, mp, fx;
    lu = ((eop == 4'h5) || (eop == 4'hB)) && (ed != 4'hF) && ((ed == sa) || (ed == sb));
    rb = (dop == 4'h9) || (eop == 4'h9) || (mop == 4'h9);
    mp = (eop == 4'h7) && !c;
    fx = (ms != 2'd0) || (ws != 2'd0);
    // {f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, set_cc}
    return {lu || rb, lu, mp || (rb && !lu), mp || lu, fx, fx, (eop == 4'h6) && !fx};
  endfunction

  task automatic idle();
    d_op = 4'h1; e_op = 4'h1; m_op = 4'h1;
    e_dst_mem = 4'hF; dec_src_a = 4'hF; dec_src_b = 4'hF;
    e_cond = 1'b1; m_stat = 2'd0; w_stat = 2'd0;
  endtask

  function automatic logic [4:0][7:0] pat(input logic [7:0] base);
    logic [4:0][7:0] p;
    for (int s = 0; s < 5; s++) p[s] = base + 8'(s);
    return p;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] ops [6];
    logic [3:0] eds [3];
    logic [4:0][7:0] pa, pb, pc, pd;
    logic [6:0] act, exp;
    string tag;
    ops = '{4'h1, 4'h5, 4'h6, 4'h7, 4'h9, 4'hB};
    eds = '{4'h2, 4'h3, 4'hF};
    idle();
    stg_d = pat(8'h40);
    sr_stall = 0; sr_bubble = 0; sr_d = 8'h00;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk_stages("R11 reset payload", {5{NOPV}});
    chk("R11 idle controls", {25'd0, f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, set_cc}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1..R8: sweep of opcode, ID, branch and status combinations
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int k = 0; k < 6; k++)
          for (int x = 0; x < 3; x++)
            for (int a = 0; a < 2; a++)
              for (int b = 0; b < 2; b++)
                for (int c = 0; c < 2; c++)
                  for (int ms = 0; ms < 4; ms++)
                    for (int ws = 0; ws < 4; ws++) begin
                      d_op = ops[i]; e_op = ops[j]; m_op = ops[k];
                      e_dst_mem = eds[x];
                      dec_src_a = a ? 4'hF : 4'h2;
                      dec_src_b = b ? 4'hF : 4'h3;
                      e_cond = c[0]; m_stat = ms[1:0]; w_stat = ws[1:0];
                      #1;
                      exp = model(d_op, e_op, m_op, e_dst_mem, dec_src_a, dec_src_b, e_cond, m_stat, w_stat);
                      act = {f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, set_cc};
                      if (exp[5] && exp[6] && (d_op == 4'h9 || e_op == 4'h9 || m_op == 4'h9) && exp[5]) tag = "R7 load/use with return";
                      else if (exp[3] && !exp[5] && exp[6]) tag = "R8 mispredict with return";
                      else if (exp[5]) tag = "R1 load/use";
                      else if (exp[6]) tag = "R3 return";
                      else if (exp[3]) tag = "R4 mispredict";
                      else if (exp[2]) tag = "R5 fault";
                      else if (e_dst_mem == 4'hF) tag = "R2 no-register ID";
                      else tag = "R6 cc enable";
                      chk(tag, {25'd0, act}, {25'd0, exp});
                      chk("R10 ctl_err", {31'd0, ctl_err}, 32'd0);
                    end

    // R9: normal advance
    @(negedge clk);
    idle();
    pa = pat(8'h40); pb = pat(8'h60); pc = pat(8'h80); pd = pat(8'hA0);
    stg_d = pa;
    @(negedge clk);
    chk_stages("R9 normal load", pa);

    // R5/R9: fault holds W, squashes M
    w_stat = 2'd2; stg_d = pb;
    @(negedge clk);
    chk_stages("R5 fault freeze", {pa[4], NOPV, pb[2], pb[1], pb[0]});
    w_stat = 2'd0;

    // R4/R9: mispredict bubbles D and E
    e_op = 4'h7; e_cond = 1'b0; stg_d = pc;
    @(negedge clk);
    chk_stages("R4 mispredict bubbles", {pc[4], pc[3], NOPV, NOPV, pc[0]});

    // R1/R9: load/use holds F and D, bubbles E
    stg_d = pb;
    @(negedge clk);
    stg_d = pd;
    idle();
    @(negedge clk);
    // now F,D,E,M,W = pd
    chk_stages("R9 reload", pd);
    e_op = 4'h5; e_dst_mem = 4'h3; dec_src_b = 4'h3; d_op = 4'h9; stg_d = pc;
    #1;
    chk("R7 decode held not bubbled", {30'd0, d_stall, d_bubble}, 32'd2);
    @(negedge clk);
    chk_stages("R7 load/use over return", {pc[4], pc[3], NOPV, pd[1], pd[0]});
    idle();

    // R10: standalone register with conflicting controls
    @(negedge clk);
    sr_d = 8'h3C;
    @(negedge clk);
    chk("R9 standalone load", {24'd0, sr_q}, 32'h3C);
    sr_stall = 1; sr_bubble = 1; sr_d = 8'h77;
    #1;
    chk("R10 conflict flag", {31'd0, sr_conf}, 32'd1);
    @(negedge clk);
    chk("R10 stall wins", {24'd0, sr_q}, 32'h3C);
    sr_stall = 0;
    #1;
    chk("R10 conflict clears", {31'd0, sr_conf}, 32'd0);
    @(negedge clk);
    chk("R9 standalone bubble", {24'd0, sr_q}, {24'd0, NOPV});
    sr_bubble = 0; sr_stall = 1; sr_d = 8'h99;
    @(negedge clk);
    chk("R9 standalone hold", {24'd0, sr_q}, {24'd0, NOPV});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule